// File: doc/BRIEF.md
# Coprocessor Interface Clockless Register Read Port

This block is the host-facing read path of a coprocessor's interface register file. The host bus controls it with active-low chip select, address strobe and data strobe, plus a read/write level and a four-bit word index taken from address lines A4..A1. The read path is purely combinational, so the cycle it serves has no timing relation to any clock. A qualifying read puts the indexed register on the data pins. It also drives the word-size acknowledge code, and both stay up until one of the two strobes is negated.

The register file is dual-ported. Coprocessor logic updates entries through a clocked write port at the same time as the host reads them. Two indices, 0 (byte offset $00) and 2 (byte offset $04), belong to a separate clocked read responder. For reads of those indices this block only raises a request flag. It never drives data for them. Write cycles from the host are not served here either.

The data pins are brought out as a value and an output enable, for the pad ring to turn into a tri-state driver.

Top module: `cop_async_rd_port`

## Requirements
- R1: With cs_n, as_n and ds_n all low, rd_wr high and host_idx not 0 or 2, the block sets bus_oe high, sets bus_dout to the register at host_idx and sets ack_n to 2'b01 (ack_n[1] low, ack_n[0] high, meaning a 16-bit port). No clock edge is involved.
- R2: A read of host_idx 0 or 2 (offsets $00 and $04) with all strobes asserted and rd_wr high keeps bus_oe low and ack_n at 2'b11, and sets sync_req high.
- R3: sync_req is low whenever the conditions of R2 do not all hold.
- R4: When as_n rises first during a served read, bus_oe drops and ack_n returns to 2'b11 at once.
- R5: When ds_n rises first during a served read, bus_oe drops and ack_n returns to 2'b11 at once.
- R6: While cs_n is high or rd_wr is low, bus_oe stays low, ack_n stays 2'b11 and sync_req stays low.
- R7: With int_we high at a rising clock edge, the entry int_idx takes int_wdata. A host read held across that edge shows the complete old word before the edge and the complete new word after it.
- R8: A synchronous active-high rst clears every register entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the internal write port |
| rst | input | 1 | Synchronous active-high reset of the register entries |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_wr | input | 1 | High for a host read, low for a host write |
| host_idx | input | 4 | Word index from address lines A4..A1 |
| bus_dout | output | 16 | Read data toward the pad driver |
| bus_oe | output | 1 | Pad output enable; low means high impedance |
| ack_n | output | 2 | Transfer/size acknowledge, active low |
| sync_req | output | 1 | Read of index 0 or 2 waiting for the clocked responder |
| int_we | input | 1 | Internal write enable |
| int_idx | input | 4 | Internal write index |
| int_wdata | input | 16 | Internal write data |

## Verification
The assertions sample the combinational port relations on rising clock edges. They therefore assume that the host strobes do not change right at a clock edge, and that between edges the strobes move only in the order a real bus cycle uses. The stability check also assumes that no host read overlaps an internal write unless that write is the event being checked. The bench changes the host pins only a few nanoseconds after a falling edge and finishes each whole strobe sequence within that half period. It raises int_we only in dedicated write slots and in the one deliberate overlap case, so every clocked property sees settled inputs.

// File: rtl/cop_rd_pkg.sv
package cop_rd_pkg;

    localparam int CRP_DATA_W = 16;
    localparam int CRP_IDX_W  = 4;
    localparam int CRP_NREG   = 1 << CRP_IDX_W;

    // word indices handed to the clocked responder (byte offsets $00, $04)
    localparam logic [CRP_IDX_W-1:0] RESP_IDX = CRP_IDX_W'(0);
    localparam logic [CRP_IDX_W-1:0] SAVE_IDX = CRP_IDX_W'(2);

    typedef enum logic [1:0] {
        ACK_NONE = 2'b11,
        ACK_WORD = 2'b01
    } ack_code_e;

    typedef struct packed {
        logic                 serve;    // clockless read served here
        logic                 defer;    // read for the clocked responder
        logic [CRP_IDX_W-1:0] idx;
    } host_req_t;

    function automatic logic is_sync_idx(input logic [CRP_IDX_W-1:0] i);
        return (i == RESP_IDX) || (i == SAVE_IDX);
    endfunction

endpackage

// File: rtl/cop_rd_decode.sv
module cop_rd_decode
    import cop_rd_pkg::*;
(
    input  logic                 cs_n,
    input  logic                 as_n,
    input  logic                 ds_n,
    input  logic                 rd_wr,
    input  logic [CRP_IDX_W-1:0] host_idx,
    output host_req_t            req
);
    logic cycle_rd;

    always_comb begin
        cycle_rd  = !cs_n && !as_n && !ds_n && rd_wr;
        req.idx   = host_idx;
        req.defer = cycle_rd && is_sync_idx(host_idx);
        req.serve = cycle_rd && !is_sync_idx(host_idx);
    end
endmodule

// File: rtl/cop_rd_regbank.sv
module cop_rd_regbank #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    localparam int NREG  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // clockless host port: whole word comes from one register
    assign rdata = mem[ridx];

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(widx)] == $past(wdata));

    for (genvar g = 0; g < NREG; g++) begin : g_rst_chk
        assert_entry_cleared_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> mem[g] == '0);
    end
endmodule

// File: rtl/cop_rd_driver.sv
module cop_rd_driver
    import cop_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  host_req_t         req,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [1:0]        ack_n,
    output logic              sync_req
);
    ack_code_e ack;

    always_comb begin
        ack      = req.serve ? ACK_WORD : ACK_NONE;
        ack_n    = ack;
        bus_oe   = req.serve;
        bus_dout = req.serve ? rdata : '0;
        sync_req = req.defer;
    end
endmodule

// File: rtl/cop_async_rd_port.sv
module cop_async_rd_port
    import cop_rd_pkg::*;
#(
    parameter int DATA_W = CRP_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 as_n,
    input  logic                 ds_n,
    input  logic                 rd_wr,
    input  logic [CRP_IDX_W-1:0] host_idx,
    output logic [DATA_W-1:0]    bus_dout,
    output logic                 bus_oe,
    output logic [1:0]           ack_n,
    output logic                 sync_req,
    input  logic                 int_we,
    input  logic [CRP_IDX_W-1:0] int_idx,
    input  logic [DATA_W-1:0]    int_wdata
);
    host_req_t         req;
    logic [DATA_W-1:0] rdata;

    cop_rd_decode u_dec (
        .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n), .rd_wr(rd_wr),
        .host_idx(host_idx), .req(req)
    );

    cop_rd_regbank #(.DATA_W(DATA_W), .IDX_W(CRP_IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(int_we), .widx(int_idx),
        .wdata(int_wdata), .ridx(req.idx), .rdata(rdata)
    );

    cop_rd_driver #(.DATA_W(DATA_W)) u_drv (
        .req(req), .rdata(rdata), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .ack_n(ack_n), .sync_req(sync_req)
    );

    assert_word_ack_R1: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ack_n == 2'b01);

    assert_excluded_idx_R2: assert property (@(posedge clk) disable iff (rst)
        (host_idx == 4'd0 || host_idx == 4'd2) |-> !bus_oe && ack_n == 2'b11);

    assert_flag_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_req, bus_oe}));

    assert_as_release_R4: assert property (@(posedge clk) disable iff (rst)
        as_n |-> !bus_oe && ack_n == 2'b11 && !sync_req);

    assert_ds_release_R5: assert property (@(posedge clk) disable iff (rst)
        ds_n |-> !bus_oe && ack_n == 2'b11 && !sync_req);

    assert_unselected_R6: assert property (@(posedge clk) disable iff (rst)
        (cs_n || !rd_wr) |-> !bus_oe && !sync_req);

    assert_read_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe) && $stable(host_idx) && !$past(int_we))
        |-> $stable(bus_dout));
endmodule

// File: tb/cop_async_rd_port_test.sv
module cop_async_rd_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1;
    logic [3:0]  host_idx = '0;
    logic [15:0] bus_dout;
    logic        bus_oe, sync_req;
    logic [1:0]  ack_n;
    logic        int_we = 1'b0;
    logic [3:0]  int_idx = '0;
    logic [15:0] int_wdata = '0;

    logic [15:0] model [16];
    int compared = 0, mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cop_async_rd_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n),
        .rd_wr(rd_wr), .host_idx(host_idx), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .ack_n(ack_n), .sync_req(sync_req),
        .int_we(int_we), .int_idx(int_idx), .int_wdata(int_wdata)
    );

    function automatic bit excluded(input logic [3:0] i);
        return i == 4'd0 || i == 4'd2;
    endfunction

    // packed view {oe, ack_n, sync_req, data}
    function automatic logic [19:0] expect_active(input logic [3:0] i);
        if (excluded(i)) return {1'b0, 2'b11, 1'b1, 16'h0};
        return {1'b1, 2'b01, 1'b0, model[i]};
    endfunction

    localparam logic [19:0] IDLE = {1'b0, 2'b11, 1'b0, 16'h0};

    task automatic check(input logic [19:0] act, input logic [19:0] exp, input string req);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got oe/ack/sync/data=%h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] pins();
        return {bus_oe, ack_n, sync_req, bus_oe ? bus_dout : 16'h0};
    endfunction

    task automatic int_write(input logic [3:0] i, input logic [15:0] d);
        @(negedge clk);
        int_we = 1'b1; int_idx = i; int_wdata = d;
        @(negedge clk);
        int_we = 1'b0;
        model[i] = d;
    endtask

    // full host read; as_first selects which strobe is negated first
    task automatic host_read(input logic [3:0] i, input bit as_first);
        @(negedge clk);
        rd_wr = 1'b1; host_idx = i; cs_n = 1'b0;
        #1 as_n = 1'b0;
        #1 ds_n = 1'b0;
        #1 check(pins(), expect_active(i), excluded(i) ? "R2" : "R1");
        if (as_first) as_n = 1'b1; else ds_n = 1'b1;
        #1 check(pins(), IDLE, as_first ? "R4" : "R5");
        as_n = 1'b1; ds_n = 1'b1;
        #1 cs_n = 1'b1;
        #1 check(pins(), IDLE, "R3");
    endtask

    task automatic gated_cycle(input logic [3:0] i, input bit use_cs);
        @(negedge clk);
        host_idx = i;
        cs_n  = use_cs ? 1'b1 : 1'b0;
        rd_wr = use_cs ? 1'b1 : 1'b0;
        #1 as_n = 1'b0;
        #1 ds_n = 1'b0;
        #1 check(pins(), IDLE, "R6");
        as_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1; rd_wr = 1'b1;
        #1;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7719));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state at the pins, then entries read as zero (R8)
        #2 check(pins(), IDLE, "R6");
        host_read(4'd5, 1'b1);
        host_read(4'd15, 1'b0);

        // fill every entry
        for (int i = 0; i < 16; i++) int_write(4'(i), 16'($urandom));

        // directed: each index, both strobe orders (R1/R2/R4/R5)
        for (int i = 0; i < 16; i++) begin
            host_read(4'(i), 1'b1);
            host_read(4'(i), 1'b0);
        end

        // patterns of all ones / alternating
        int_write(4'd1, 16'hFFFF); host_read(4'd1, 1'b0);
        int_write(4'd3, 16'hAAAA); host_read(4'd3, 1'b1);
        int_write(4'd2, 16'h5555); host_read(4'd2, 1'b1);

        // R6: chip select negated, and host write cycles
        for (int i = 0; i < 16; i++) begin
            gated_cycle(4'(i), 1'b1);
            gated_cycle(4'(i), 1'b0);
        end

        // R7: read held across an internal write to the same entry
        @(negedge clk);
        rd_wr = 1'b1; host_idx = 4'd9; cs_n = 1'b0;
        #1 as_n = 1'b0; #1 ds_n = 1'b0;
        #1 check(pins(), {1'b1, 2'b01, 1'b0, model[9]}, "R7 before edge");
        int_we = 1'b1; int_idx = 4'd9; int_wdata = ~model[9];
        @(posedge clk);
        #2 check(pins(), {1'b1, 2'b01, 1'b0, ~model[9]}, "R7 after edge");
        @(negedge clk);
        int_we = 1'b0; model[9] = ~model[9];
        #1 ds_n = 1'b1;
        #1 check(pins(), IDLE, "R5");
        as_n = 1'b1; cs_n = 1'b1;

        // random mix of writes and reads
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 2) == 0)
                int_write(4'($urandom_range(0, 15)), 16'($urandom));
            else if ($urandom_range(0, 4) == 0)
                gated_cycle(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
            else
                host_read(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
        end

        // R8: reset after data was written
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        host_read(4'd7, 1'b1);
        host_read(4'd12, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule